// File: doc/BRIEF.md
# Four-Channel Interval Timer Bank

This block holds four independent 16-bit up-counters behind a small register bus. Each timer has a count value, a mode word and a compare value. Timers 0 and 1 also carry a plain read/write hold word. A one-cycle `tick` strobe advances every timer whose count-enable bit is set. A timer fires when its count reaches the compare value with compare events enabled, or when its count wraps past 0xFFFF with overflow events enabled. Each firing produces a one-cycle pulse on that timer's line of a 16-bit interrupt vector, which feeds an external interrupt controller. Timer i drives line 9+i.

Timer 0 is periodic and stays armed after it fires. Timers 1 to 3 are single-shot: when they fire, they clear their own compare-enable bit and their wrap flag. Bits [12:11] of the byte address select the timer, and bits [10:0] select the register inside that timer's window. A small bus state machine has three states: BUS_IDLE, BUS_RDATA and BUS_ERROR. Every clock it moves to BUS_ERROR on an access to a hold word that does not exist, to BUS_RDATA on any other read, and to BUS_IDLE otherwise. BUS_RDATA presents the read data with `rvalid`. BUS_ERROR raises `acc_err`. Neither state outputs anything in the cycle of the access.

Top module: `timer_bank`

## Requirements
- R1: After reset every count, mode, compare and hold value reads as 0, and `rvalid`, `acc_err` and `intc_irq` are 0.
- R2: Address bits [12:11] pick the timer. Window offset 0x00 is count, 0x10 is mode, 0x20 is compare and 0x30 is hold. A read issued in cycle t returns its data with `rvalid`=1 in cycle t+1 only. Any other offset reads 0 and ignores writes. Mode reads back only bits 6, 7, 8, 9 and 11. When `wr_en` and `rd_en` are both high, the access is a write.
- R3: While mode bit 7 (count enable) is 1, each cycle with `tick`=1 adds 1 to the count. With bit 7 clear, or with `tick` low, the count holds.
- R4: A count write in the same cycle as a tick loads the written value, and that tick is ignored for the timer.
- R5: With mode bit 8 (compare enable) set, a tick that brings the count to the compare value raises `intc_irq[9+i]` for exactly the next cycle.
- R6: A tick that wraps the count from 0xFFFF to 0 sets mode bit 11. Writing 1 to bit 11 clears it. If mode bit 9 (overflow enable) is set, the wrap also fires the interrupt.
- R7: When a timer fires and mode bit 6 (zero return) is set, the count becomes 0 instead of the incremented value.
- R8: Timer 0 keeps bit 8 set after firing and fires again on later matches. Timers 1 to 3 clear bits 8 and 11 when they fire, so they do not fire again on a later match.
- R9: Hold words exist on timers 0 and 1. A read or write at offset 0x30 on timer 2 or 3 raises `acc_err` for one cycle. A write there is dropped, and a read gives no `rvalid` and reads 0.
- R10: `intc_irq` bits other than 9 to 12 are always 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Advance strobe for all enabled timers |
| wr_en | input | 1 | Register write request |
| rd_en | input | 1 | Register read request |
| addr | input | 13 | Byte address; [12:11] timer, [10:0] offset |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data, valid with rvalid |
| rvalid | output | 1 | Read response, one cycle after rd_en |
| acc_err | output | 1 | Access to a missing hold word |
| intc_irq | output | 16 | Interrupt lines; timer i on bit 9+i |

## Verification
The hardest situations to reach are those where two things happen on the same edge, and those where a firing must not repeat. The stimulus gets there as follows:
- To test a count write against a tick, it raises `tick` and a count write in the same cycle.
- To test a wrap, it first loads the count with 0xFFFE or 0xFFFF through the bus.
- To test single-shot behaviour, it rewinds a timer that has already fired below its compare value and then steps it through the match again, expecting no pulse.
- To test that timer 0 stays periodic, it uses zero return and steps through a second full period.

// File: rtl/timer_pkg.sv
package timer_pkg;
    // mode word bit positions
    localparam int MB_ZRET = 6;
    localparam int MB_CEN  = 7;
    localparam int MB_CMPE = 8;
    localparam int MB_OVFE = 9;
    localparam int MB_WRAP = 11;

    // register offsets inside a timer window
    localparam int OFF_COUNT = 'h00;
    localparam int OFF_MODE  = 'h10;
    localparam int OFF_CMP   = 'h20;
    localparam int OFF_HOLD  = 'h30;

    typedef enum logic [1:0] {
        BUS_IDLE  = 2'd0,
        BUS_RDATA = 2'd1,
        BUS_ERROR = 2'd2
    } bus_state_t;
endpackage

// File: rtl/timer_chan.sv
module timer_chan
    import timer_pkg::*;
#(
    parameter int CNT_W    = 16,
    parameter bit ONE_SHOT = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             wr_cnt,
    input  logic             wr_mode,
    input  logic             wr_cmp,
    input  logic [CNT_W-1:0] wdata,
    output logic [CNT_W-1:0] cnt_o,
    output logic [CNT_W-1:0] mode_o,
    output logic [CNT_W-1:0] cmp_o,
    output logic             irq_o
);
    logic [CNT_W-1:0] cnt_q, cnt_n, cmp_q, cnt_inc;
    logic zret_q, cen_q, cmpe_q, ovfe_q, wrap_q;
    logic zret_n, cen_n, cmpe_n, ovfe_n, wrap_n;
    logic inc, wrap_ev, hit_cmp, hit_ovf, fire;

    always_comb begin
        inc     = tick & cen_q & ~wr_cnt;
        cnt_inc = cnt_q + 1'b1;
        wrap_ev = inc & (cnt_q == {CNT_W{1'b1}});
        hit_cmp = inc & cmpe_q & (cnt_inc == cmp_q);
        hit_ovf = wrap_ev & ovfe_q;
        fire    = hit_cmp | hit_ovf;

        if (wr_cnt)
            cnt_n = wdata;
        else if (inc)
            cnt_n = (fire && zret_q) ? '0 : cnt_inc;
        else
            cnt_n = cnt_q;

        zret_n = wr_mode ? wdata[MB_ZRET] : zret_q;
        cen_n  = wr_mode ? wdata[MB_CEN]  : cen_q;
        cmpe_n = wr_mode ? wdata[MB_CMPE] : cmpe_q;
        ovfe_n = wr_mode ? wdata[MB_OVFE] : ovfe_q;
        wrap_n = (wrap_q & ~(wr_mode & wdata[MB_WRAP])) | wrap_ev;

        if (ONE_SHOT && fire) begin
            wrap_n = 1'b0;
            if (!wr_mode)
                cmpe_n = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            cmp_q  <= '0;
            zret_q <= 1'b0;
            cen_q  <= 1'b0;
            cmpe_q <= 1'b0;
            ovfe_q <= 1'b0;
            wrap_q <= 1'b0;
            irq_o  <= 1'b0;
        end else begin
            cnt_q  <= cnt_n;
            cmp_q  <= wr_cmp ? wdata : cmp_q;
            zret_q <= zret_n;
            cen_q  <= cen_n;
            cmpe_q <= cmpe_n;
            ovfe_q <= ovfe_n;
            wrap_q <= wrap_n;
            irq_o  <= fire;
        end
    end

    always_comb begin
        mode_o          = '0;
        mode_o[MB_ZRET] = zret_q;
        mode_o[MB_CEN]  = cen_q;
        mode_o[MB_CMPE] = cmpe_q;
        mode_o[MB_OVFE] = ovfe_q;
        mode_o[MB_WRAP] = wrap_q;
        cnt_o           = cnt_q;
        cmp_o           = cmp_q;
    end
endmodule

// File: rtl/timer_bus_fsm.sv
module timer_bus_fsm
    import timer_pkg::*;
#(
    parameter int NUM_TIMERS = 4,
    parameter int NUM_HOLD   = 2,
    parameter int CNT_W      = 16,
    parameter int SEL_LSB    = 11,
    localparam int SEL_W     = $clog2(NUM_TIMERS),
    localparam int ADDR_W    = SEL_LSB + SEL_W
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 wr_en,
    input  logic                                 rd_en,
    input  logic [ADDR_W-1:0]                    addr,
    input  logic [NUM_TIMERS-1:0][CNT_W-1:0]     cnt_i,
    input  logic [NUM_TIMERS-1:0][CNT_W-1:0]     mode_i,
    input  logic [NUM_TIMERS-1:0][CNT_W-1:0]     cmp_i,
    input  logic [NUM_HOLD-1:0][CNT_W-1:0]       hold_i,
    output logic [NUM_TIMERS-1:0]                wr_cnt,
    output logic [NUM_TIMERS-1:0]                wr_mode,
    output logic [NUM_TIMERS-1:0]                wr_cmp,
    output logic [NUM_HOLD-1:0]                  wr_hold,
    output logic [CNT_W-1:0]                     rdata,
    output logic                                 rvalid,
    output logic                                 acc_err
);
    bus_state_t        state_q, state_n;
    logic [SEL_W-1:0]  sel;
    logic [SEL_LSB-1:0] off;
    logic is_cnt, is_mode, is_cmp, is_hold, hold_bad, err_acc, rd_ok;
    logic [CNT_W-1:0]  rd_val, rdata_q;

    always_comb begin
        sel      = addr[SEL_LSB +: SEL_W];
        off      = addr[SEL_LSB-1:0];
        is_cnt   = (off == SEL_LSB'(OFF_COUNT));
        is_mode  = (off == SEL_LSB'(OFF_MODE));
        is_cmp   = (off == SEL_LSB'(OFF_CMP));
        is_hold  = (off == SEL_LSB'(OFF_HOLD));
        hold_bad = is_hold && (int'(sel) >= NUM_HOLD);
        err_acc  = (wr_en | rd_en) & hold_bad;
        rd_ok    = rd_en & ~wr_en & ~hold_bad;
    end

    // write strobes and read multiplexer
    always_comb begin
        rd_val = '0;
        for (int t = 0; t < NUM_TIMERS; t++) begin
            wr_cnt[t]  = wr_en && is_cnt  && (sel == SEL_W'(t));
            wr_mode[t] = wr_en && is_mode && (sel == SEL_W'(t));
            wr_cmp[t]  = wr_en && is_cmp  && (sel == SEL_W'(t));
            if (sel == SEL_W'(t)) begin
                if (is_cnt)  rd_val = cnt_i[t];
                if (is_mode) rd_val = mode_i[t];
                if (is_cmp)  rd_val = cmp_i[t];
            end
        end
        for (int h = 0; h < NUM_HOLD; h++) begin
            wr_hold[h] = wr_en && is_hold && (sel == SEL_W'(h));
            if (is_hold && (sel == SEL_W'(h)))
                rd_val = hold_i[h];
        end
    end

    // next state
    always_comb begin
        unique case (state_q)
            BUS_IDLE, BUS_RDATA, BUS_ERROR: begin
                if (err_acc)
                    state_n = BUS_ERROR;
                else if (rd_ok)
                    state_n = BUS_RDATA;
                else
                    state_n = BUS_IDLE;
            end
            default: state_n = BUS_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= BUS_IDLE;
            rdata_q <= '0;
        end else begin
            state_q <= state_n;
            rdata_q <= rd_ok ? rd_val : '0;
        end
    end

    // outputs
    always_comb begin
        rvalid  = 1'b0;
        acc_err = 1'b0;
        rdata   = '0;
        unique case (state_q)
            BUS_RDATA: begin
                rvalid = 1'b1;
                rdata  = rdata_q;
            end
            BUS_ERROR: acc_err = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/timer_bank.sv
module timer_bank
    import timer_pkg::*;
#(
    parameter int NUM_TIMERS = 4,
    parameter int NUM_HOLD   = 2,
    parameter int CNT_W      = 16,
    parameter int SEL_LSB    = 11,
    parameter int IRQ_BASE   = 9,
    parameter int INTC_W     = 16,
    localparam int SEL_W     = $clog2(NUM_TIMERS),
    localparam int ADDR_W    = SEL_LSB + SEL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [CNT_W-1:0]  wdata,
    output logic [CNT_W-1:0]  rdata,
    output logic              rvalid,
    output logic              acc_err,
    output logic [INTC_W-1:0] intc_irq
);
    logic [NUM_TIMERS-1:0][CNT_W-1:0] chan_cnt, chan_mode, chan_cmp;
    logic [NUM_HOLD-1:0][CNT_W-1:0]   hold_q;
    logic [NUM_TIMERS-1:0] wr_cnt, wr_mode, wr_cmp, chan_irq;
    logic [NUM_HOLD-1:0]   wr_hold;

    timer_bus_fsm #(
        .NUM_TIMERS(NUM_TIMERS), .NUM_HOLD(NUM_HOLD),
        .CNT_W(CNT_W), .SEL_LSB(SEL_LSB)
    ) u_bus (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .cnt_i(chan_cnt), .mode_i(chan_mode), .cmp_i(chan_cmp), .hold_i(hold_q),
        .wr_cnt(wr_cnt), .wr_mode(wr_mode), .wr_cmp(wr_cmp), .wr_hold(wr_hold),
        .rdata(rdata), .rvalid(rvalid), .acc_err(acc_err)
    );

    for (genvar t = 0; t < NUM_TIMERS; t++) begin : g_chan
        timer_chan #(
            .CNT_W(CNT_W),
            .ONE_SHOT(t != 0)
        ) u_chan (
            .clk(clk), .rst_n(rst_n), .tick(tick),
            .wr_cnt(wr_cnt[t]), .wr_mode(wr_mode[t]), .wr_cmp(wr_cmp[t]),
            .wdata(wdata),
            .cnt_o(chan_cnt[t]), .mode_o(chan_mode[t]), .cmp_o(chan_cmp[t]),
            .irq_o(chan_irq[t])
        );
    end

    for (genvar h = 0; h < NUM_HOLD; h++) begin : g_hold
        always_ff @(posedge clk) begin
            if (!rst_n)
                hold_q[h] <= '0;
            else if (wr_hold[h])
                hold_q[h] <= wdata;
        end
    end

    always_comb begin
        intc_irq = '0;
        for (int t = 0; t < NUM_TIMERS; t++)
            intc_irq[IRQ_BASE + t] = chan_irq[t];
    end
endmodule

// File: rtl/timer_bank_chk.sv
module timer_bank_chk
    import timer_pkg::*;
#(
    parameter int NUM_TIMERS = 4,
    parameter int NUM_HOLD   = 2,
    parameter int CNT_W      = 16,
    parameter int SEL_LSB    = 11,
    parameter int IRQ_BASE   = 9,
    parameter int INTC_W     = 16,
    localparam int SEL_W     = $clog2(NUM_TIMERS),
    localparam int ADDR_W    = SEL_LSB + SEL_W
) (
    input logic                             clk,
    input logic                             rst_n,
    input logic                             tick,
    input logic                             wr_en,
    input logic                             rd_en,
    input logic [ADDR_W-1:0]                addr,
    input logic                             rvalid,
    input logic                             acc_err,
    input logic [INTC_W-1:0]                intc_irq,
    input logic [NUM_TIMERS-1:0][CNT_W-1:0] chan_cnt,
    input logic [NUM_TIMERS-1:0][CNT_W-1:0] chan_mode
);
    // R2
    rd_response_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rvalid |-> $past(rd_en && !wr_en));

    // R3
    count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !wr_en) |=> $stable(chan_cnt));

    // R9
    hold_error_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_err |-> $past((rd_en || wr_en)
                          && (int'(addr[SEL_LSB +: SEL_W]) >= NUM_HOLD)
                          && (addr[SEL_LSB-1:0] == SEL_LSB'(OFF_HOLD))));

    for (genvar t = 0; t < NUM_TIMERS; t++) begin : g_tchk
        // R5
        irq_after_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
            intc_irq[IRQ_BASE + t] |-> $past(tick));
        if (t != 0) begin : g_single
            // R8
            single_shot_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (intc_irq[IRQ_BASE + t] && !$past(wr_en)) |-> !chan_mode[t][MB_CMPE]);
        end
    end
endmodule

bind timer_bank timer_bank_chk #(
    .NUM_TIMERS(NUM_TIMERS), .NUM_HOLD(NUM_HOLD), .CNT_W(CNT_W),
    .SEL_LSB(SEL_LSB), .IRQ_BASE(IRQ_BASE), .INTC_W(INTC_W)
) u_timer_bank_chk (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .rvalid(rvalid), .acc_err(acc_err), .intc_irq(intc_irq),
    .chan_cnt(chan_cnt), .chan_mode(chan_mode)
);

// File: tb/test_timer_bank.sv
`timescale 1ns/1ps
module test_timer_bank;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [12:0] addr = '0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic        rvalid;
    logic        acc_err;
    logic [15:0] intc_irq;

    int total = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    timer_bank i_timer_bank (
        .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .rvalid(rvalid),
        .acc_err(acc_err), .intc_irq(intc_irq)
    );

    typedef struct packed {
        logic [1:0]  op;
        logic [12:0] adr;
        logic [15:0] dat;
        logic [15:0] exp;
    } vec_t;

    localparam logic [1:0] OP_WR = 2'd0, OP_RD = 2'd1, OP_TK = 2'd2;
    localparam int NV = 22;
    localparam vec_t VECS [NV] = '{
        '{OP_WR, 13'h0020, 16'h1234, 16'h0000},  // R2 compare t0
        '{OP_RD, 13'h0020, 16'h0000, 16'h1234},
        '{OP_WR, 13'h0830, 16'h00AB, 16'h0000},  // R9 hold t1
        '{OP_RD, 13'h0830, 16'h0000, 16'h00AB},
        '{OP_WR, 13'h0030, 16'h5555, 16'h0000},  // R9 hold t0
        '{OP_RD, 13'h0030, 16'h0000, 16'h5555},
        '{OP_WR, 13'h1000, 16'h0042, 16'h0000},  // R2 count t2
        '{OP_RD, 13'h1000, 16'h0000, 16'h0042},
        '{OP_WR, 13'h0810, 16'hFFFF, 16'h0000},  // R2 mode readback mask
        '{OP_RD, 13'h0810, 16'h0000, 16'h03C0},
        '{OP_WR, 13'h0810, 16'h0000, 16'h0000},
        '{OP_WR, 13'h0040, 16'h7777, 16'h0000},  // R2 unmapped offset
        '{OP_RD, 13'h0040, 16'h0000, 16'h0000},
        '{OP_WR, 13'h1800, 16'h0005, 16'h0000},  // R3 counting t3
        '{OP_WR, 13'h1810, 16'h0080, 16'h0000},
        '{OP_TK, 13'h0000, 16'h0003, 16'h0000},
        '{OP_RD, 13'h1800, 16'h0000, 16'h0008},
        '{OP_WR, 13'h1810, 16'h0000, 16'h0000},  // R3 disabled holds
        '{OP_TK, 13'h0000, 16'h0002, 16'h0000},
        '{OP_RD, 13'h1800, 16'h0000, 16'h0008},
        '{OP_RD, 13'h1000, 16'h0000, 16'h0042},  // R3 t2 not enabled
        '{OP_RD, 13'h0800, 16'h0000, 16'h0000}   // R2 t1 count untouched
    };

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [12:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [12:0] a, output logic [15:0] d, output logic v);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        d = rdata;
        v = rvalid;
    endtask

    task automatic rd_chk(input string tag, input logic [12:0] a, input logic [15:0] exp);
        logic [15:0] d;
        logic v;
        rd(a, d, v);
        chk({tag, " rvalid"}, {15'b0, v}, 16'h0001);
        chk(tag, d, exp);
    endtask

    task automatic tk(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            tick = 1'b1;
            @(negedge clk);
            tick = 1'b0;
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", total - fails, total);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            fails++;
            $display("FAIL watchdog: actual running expected finished");
            summary();
            $finish;
        end
    end

    initial begin
        logic [15:0] d;
        logic v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 rvalid", {15'b0, rvalid}, 16'h0);
        chk("R1 acc_err", {15'b0, acc_err}, 16'h0);
        chk("R1 intc_irq", intc_irq, 16'h0);
        rd_chk("R1 mode t3", 13'h1810, 16'h0);
        rd_chk("R1 hold t1", 13'h0830, 16'h0);
        rd_chk("R1 count t0", 13'h0000, 16'h0);

        // table walk
        for (int k = 0; k < NV; k++) begin
            case (VECS[k].op)
                OP_WR: wr(VECS[k].adr, VECS[k].dat);
                OP_RD: rd_chk($sformatf("table[%0d] (R2,R3,R9)", k), VECS[k].adr, VECS[k].exp);
                default: tk(int'(VECS[k].dat));
            endcase
        end

        // R4 count write beats a same-cycle tick
        wr(13'h0000, 16'h0100);
        wr(13'h0010, 16'h0080);
        @(negedge clk);
        tick = 1'b1; wr_en = 1'b1; addr = 13'h0000; wdata = 16'h0200;
        @(negedge clk);
        tick = 1'b0; wr_en = 1'b0;
        rd_chk("R4 write over tick", 13'h0000, 16'h0200);
        tk(1);
        rd_chk("R3 increment after write", 13'h0000, 16'h0201);
        wr(13'h0010, 16'h0000);

        // R5 compare fire on timer 0, R10 other lines quiet
        wr(13'h0000, 16'h0000);
        wr(13'h0020, 16'h0003);
        wr(13'h0010, 16'h0180);
        tk(2);
        chk("R5 no early fire", intc_irq, 16'h0000);
        tk(1);
        chk("R5 R10 t0 fire line 9", intc_irq, 16'h0200);
        rd_chk("R5 count at match", 13'h0000, 16'h0003);
        rd_chk("R8 t0 stays armed", 13'h0010, 16'h0180);
        wr(13'h0010, 16'h0000);

        // R7 zero return, R8 periodic refire
        wr(13'h0000, 16'h0000);
        wr(13'h0020, 16'h0002);
        wr(13'h0010, 16'h01C0);
        tk(2);
        chk("R7 fire with zero return", intc_irq, 16'h0200);
        rd_chk("R7 count returned to 0", 13'h0000, 16'h0000);
        tk(2);
        chk("R8 t0 periodic refire", intc_irq, 16'h0200);
        wr(13'h0010, 16'h0000);

        // R8 single shot on timer 1
        wr(13'h0800, 16'h0000);
        wr(13'h0820, 16'h0002);
        wr(13'h0810, 16'h0180);
        tk(2);
        chk("R5 t1 fire line 10", intc_irq, 16'h0400);
        rd_chk("R8 t1 compare enable cleared", 13'h0810, 16'h0080);
        wr(13'h0800, 16'h0001);
        tk(1);
        chk("R8 t1 no second fire", intc_irq, 16'h0000);
        rd_chk("R8 t1 count passed match", 13'h0800, 16'h0002);
        wr(13'h0810, 16'h0000);

        // R6 wrap flag on timer 0 without overflow enable
        wr(13'h0000, 16'hFFFF);
        wr(13'h0010, 16'h0080);
        tk(1);
        chk("R6 no fire without enable", intc_irq, 16'h0000);
        rd_chk("R6 wrap flag set", 13'h0010, 16'h0880);
        rd_chk("R6 count wrapped", 13'h0000, 16'h0000);
        wr(13'h0010, 16'h0880);
        rd_chk("R6 wrap flag write-1 clear", 13'h0010, 16'h0080);
        wr(13'h0010, 16'h0000);

        // R6 overflow fire on timer 3
        wr(13'h1800, 16'hFFFE);
        wr(13'h1810, 16'h0280);
        tk(1);
        chk("R6 t3 not yet", intc_irq, 16'h0000);
        tk(1);
        chk("R6 R10 t3 overflow line 12", intc_irq, 16'h1000);
        rd_chk("R8 t3 wrap flag cleared", 13'h1810, 16'h0280);
        rd_chk("R6 t3 count wrapped", 13'h1800, 16'h0000);
        wr(13'h1810, 16'h0000);

        // R9 missing hold words
        wr(13'h1030, 16'h1111);
        chk("R9 write error", {15'b0, acc_err}, 16'h0001);
        rd(13'h1830, d, v);
        chk("R9 read error flag", {15'b0, acc_err}, 16'h0001);
        chk("R9 read no rvalid", {15'b0, v}, 16'h0000);
        chk("R9 read data zero", d, 16'h0000);
        rd_chk("R9 t0 hold intact", 13'h0030, 16'h5555);
        chk("R9 no error on valid hold", {15'b0, acc_err}, 16'h0000);

        done = 1'b1;
        summary();
        $finish;
    end
endmodule